// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and an asynchronous static RAM of 524,288 bytes. The host hands it one request at a time over a valid/ready port: either a read of one byte or a write of one byte. The controller then produces the memory's active-low chip select, write strobe and output enable, holds the 19-bit address, and handles the shared 8-bit data bus. Its side of that bus is split into an outgoing byte, a tri-state enable and an incoming byte, so the pad buffer lives outside. Read data comes back to the host with a single-cycle valid pulse.

Every interval is a count of system clock cycles, given as a parameter and rounded up from the memory's nanosecond limits. These intervals are the read access, the write pulse, the data hold after the write and the bus turnaround. A parameter selects one of two write waveforms. In the first, output enable stays high and a setup interval separates it from the falling write strobe, which allows the shorter write pulse. In the second, output enable stays low through the write, so a longer pulse is needed. In that case chip select and write strobe fall on the same edge, so the memory never drives the bus. After every access the chip is deselected for one turnaround interval before the next request is taken.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset, mem_cs_n, mem_we_n and mem_oe_n are 1 (all strobes are active-low), mem_dq_oe is 0, rd_valid is 0 and req_ready is 1, and nothing changes while req_valid stays 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 for the whole access, and request inputs that change while it is 0 have no effect.
- R3: A read (req_we = 0) holds mem_cs_n = 0, mem_oe_n = 0 and mem_we_n = 1 for T_RD cycles. mem_dq_in is sampled on the edge that ends the last of them, and the byte is shown on rd_data while rd_valid is 1 for exactly one cycle. Writes produce no rd_valid.
- R4: A write (req_we = 1) holds mem_we_n at 0 for exactly T_WP_OEH cycles when WR_OE_LOW = 0 and T_WP_OEL cycles when WR_OE_LOW = 1, with mem_cs_n at 0 for that whole time.
- R5: With WR_OE_LOW = 0, mem_oe_n is 1 throughout the write. Before mem_we_n falls, the chip is selected with mem_oe_n and mem_we_n both 1 for exactly T_TURN cycles.
- R6: With WR_OE_LOW = 1, mem_oe_n is 0 during the write pulse, and mem_cs_n falls on the same edge as mem_we_n.
- R7: mem_dq_oe is 1 for exactly the write-pulse cycles plus the following T_HOLD cycles. The chip is deselected during the hold, and mem_dq_oe is never 1 while the memory could drive (mem_cs_n = 0, mem_we_n = 1, mem_oe_n = 0).
- R8: Every access ends with T_TURN cycles of mem_cs_n = 1 before req_ready returns. req_ready is therefore 0 for T_RD+T_TURN cycles on a read, T_TURN+T_WP_OEH+T_HOLD+T_TURN cycles on a write with WR_OE_LOW = 0, and T_WP_OEL+T_HOLD+T_TURN cycles on a write with WR_OE_LOW = 1.
- R9: mem_addr holds the accepted address for as long as mem_cs_n is 0, and mem_dq_out holds the accepted write byte for as long as mem_dq_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Controller is idle and takes a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Byte to write |
| rd_valid | output | 1 | One-cycle pulse, rd_data holds read byte |
| rd_data | output | DW | Byte returned by a read |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | AW | Memory address lines |
| mem_dq_out | output | DW | Byte driven towards the data pins |
| mem_dq_oe | output | 1 | Enables the data pin drivers |
| mem_dq_in | input | DW | Byte read from the data pins |

## Verification
The bench builds two copies of the block, one per write style. Both use T_RD = 2, T_TURN = 2, T_HOLD = 1, T_WP_OEH = 2 and T_WP_OEL = 3. Because the intervals are longer than one cycle and differ from each other, a pulse that is off by one cycle, or an interval that takes its length from the wrong parameter, changes a measured width or the busy count of an access. A bus model answers reads only while chip select and output enable are low and the write strobe is high, and it returns a junk byte at every other time. This ties a mistimed capture or a misplaced write strobe to a wrong byte. Addresses are drawn so that reads often return earlier writes, and the all-ones and all-zeros addresses are covered directly.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int WR_OE_LOW = 0,
  parameter int T_RD      = 1,
  parameter int T_WP_OEH  = 1,
  parameter int T_WP_OEL  = 1,
  parameter int T_TURN    = 1,
  parameter int T_HOLD    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int T_WP = (WR_OE_LOW != 0) ? T_WP_OEL : T_WP_OEH;
  localparam int M1   = (T_RD > T_WP) ? T_RD : T_WP;
  localparam int M2   = (T_TURN > T_HOLD) ? T_TURN : T_HOLD;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WP, S_WHOLD, S_GAP} st_t;

  st_t st, nst;
  logic [CW-1:0] cnt;
  logic last;

  function automatic logic [CW-1:0] len_m1(st_t s);
    case (s)
      S_RD:    return CW'(T_RD - 1);
      S_WSET:  return CW'(T_TURN - 1);
      S_WP:    return CW'(T_WP - 1);
      S_WHOLD: return CW'(T_HOLD - 1);
      S_GAP:   return CW'(T_TURN - 1);
      default: return '0;
    endcase
  endfunction

  assign last      = (cnt == '0);
  assign req_ready = (st == S_IDLE);

  always_comb begin
    nst = st;
    case (st)
      S_IDLE:  if (req_valid) nst = !req_we ? S_RD : ((WR_OE_LOW != 0) ? S_WP : S_WSET);
      S_RD:    if (last) nst = S_GAP;
      S_WSET:  if (last) nst = S_WP;
      S_WP:    if (last) nst = S_WHOLD;
      S_WHOLD: if (last) nst = S_GAP;
      S_GAP:   if (last) nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      st <= nst;
      if (nst != st) cnt <= len_m1(nst);
      else if (!last) cnt <= cnt - 1'b1;
      mem_cs_n  <= !(nst == S_RD || nst == S_WSET || nst == S_WP);
      mem_we_n  <= (nst != S_WP);
      mem_oe_n  <= !(nst == S_RD || (WR_OE_LOW != 0 && nst == S_WP));
      mem_dq_oe <= (nst == S_WP || nst == S_WHOLD);
      if (st == S_IDLE && req_valid) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      rd_valid <= (st == S_RD) && last;
      if (st == S_RD && last) rd_data <= mem_dq_in;
    end
  end

  logic [CW-1:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lo_run <= '0;
    else if (!mem_we_n) lo_run <= lo_run + 1'b1;
    else                lo_run <= '0;
  end

  p_take_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (lo_run == CW'(T_WP)));

  p_no_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_cs_n || !mem_we_n || mem_oe_n));

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> !req_ready);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  generate
    if (WR_OE_LOW == 0) begin : g_oe_high
      p_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (mem_oe_n && $past(mem_oe_n) && !$past(mem_cs_n)));
      p_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    end else begin : g_oe_low
      p_joint_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($fell(mem_cs_n) && !mem_oe_n));
    end
  endgenerate
endmodule

// File: tb/test_sram_ctl.sv
module test_sram_ctl;
  localparam int RD = 2, WPH = 2, WPL = 3, TURN = 2, HOLD = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid [2];
  logic        req_ready [2];
  logic        req_we    [2];
  logic [18:0] req_addr  [2];
  logic [7:0]  req_wdata [2];
  logic        rd_valid  [2];
  logic [7:0]  rd_data   [2];
  logic        cs_n [2], we_n [2], oe_n [2], dq_oe [2];
  logic [18:0] maddr [2];
  logic [7:0]  dq_out [2], dq_in [2];

  int checks = 0;
  int errors = 0;
  logic [18:0] exp_addr [2];
  logic [7:0]  exp_wd [2];
  logic [7:0]  exp_rd [2];
  int          rd_cnt [2];
  logic [7:0]  ref_mem [2][1024];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  sram_ctl #(.WR_OE_LOW(0), .T_RD(RD), .T_WP_OEH(WPH), .T_WP_OEL(WPL), .T_TURN(TURN), .T_HOLD(HOLD)) i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_we(req_we[0]),
    .req_addr(req_addr[0]), .req_wdata(req_wdata[0]), .rd_valid(rd_valid[0]), .rd_data(rd_data[0]),
    .mem_cs_n(cs_n[0]), .mem_we_n(we_n[0]), .mem_oe_n(oe_n[0]), .mem_addr(maddr[0]),
    .mem_dq_out(dq_out[0]), .mem_dq_oe(dq_oe[0]), .mem_dq_in(dq_in[0]));

  sram_ctl #(.WR_OE_LOW(1), .T_RD(RD), .T_WP_OEH(WPH), .T_WP_OEL(WPL), .T_TURN(TURN), .T_HOLD(HOLD)) i_sram_ctl_oel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_we(req_we[1]),
    .req_addr(req_addr[1]), .req_wdata(req_wdata[1]), .rd_valid(rd_valid[1]), .rd_data(rd_data[1]),
    .mem_cs_n(cs_n[1]), .mem_we_n(we_n[1]), .mem_oe_n(oe_n[1]), .mem_addr(maddr[1]),
    .mem_dq_out(dq_out[1]), .mem_dq_oe(dq_oe[1]), .mem_dq_in(dq_in[1]));

  for (genvar k = 0; k < 2; k++) begin : g_ch
    localparam int WP = (k == 1) ? WPL : WPH;
    logic [7:0] mem [1024];
    logic [7:0] wlatch;
    logic pwe_n = 1'b1, pcs_n = 1'b1, prd = 1'b0;
    int we_lo = 0, drv_run = 0, sel_run = 0;

    initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

    assign dq_in[k] = (!cs_n[k] && !oe_n[k] && we_n[k]) ? mem[maddr[k][9:0]] : 8'hEE;

    always @(negedge clk) begin
      if (rst_n) begin
        if (dq_oe[k] && !cs_n[k] && we_n[k] && !oe_n[k]) chk(1'b0, "R7 bus clash", 1, 0);
        if (!cs_n[k]) chk(maddr[k] == exp_addr[k], "R9 address", int'(maddr[k]), int'(exp_addr[k]));
        if (dq_oe[k]) chk(dq_out[k] == exp_wd[k], "R9 write byte", int'(dq_out[k]), int'(exp_wd[k]));
        if (!we_n[k]) chk(dq_oe[k] && !cs_n[k], "R4 strobe with select and drive", int'(dq_oe[k]), 1);
        if (k == 0 && !we_n[k]) chk(oe_n[k], "R5 oe high in write", int'(oe_n[k]), 1);
        if (pwe_n && !we_n[k]) begin
          if (k == 0) chk(sel_run == TURN, "R5 setup before strobe", sel_run, TURN);
          else chk(pcs_n && !cs_n[k] && !oe_n[k], "R6 joint fall", int'(pcs_n), 1);
        end
        if (!pwe_n && we_n[k]) chk(we_lo == WP, "R4 pulse width", we_lo, WP);
        if (drv_run != 0 && !dq_oe[k]) chk(drv_run == WP + HOLD, "R7 drive window", drv_run, WP + HOLD);
        if (rd_valid[k]) begin
          chk(rd_data[k] == exp_rd[k], "R3 read byte", int'(rd_data[k]), int'(exp_rd[k]));
          chk(!prd, "R3 single pulse", int'(prd), 0);
          rd_cnt[k]++;
        end
        if (!we_n[k] && !cs_n[k] && dq_oe[k]) wlatch = dq_out[k];
        if (!pwe_n && !pcs_n && (we_n[k] || cs_n[k])) mem[maddr[k][9:0]] = wlatch;
        we_lo   = !we_n[k] ? we_lo + 1 : 0;
        drv_run = dq_oe[k] ? drv_run + 1 : 0;
        sel_run = (!cs_n[k] && oe_n[k] && we_n[k]) ? sel_run + 1 : 0;
        pwe_n = we_n[k];
        pcs_n = cs_n[k];
        prd   = rd_valid[k];
      end
    end
  end

  task automatic op(input int k, input bit we, input logic [18:0] a, input logic [7:0] d);
    int busy = 0;
    int rc0;
    int expd;
    @(negedge clk);
    while (!req_ready[k]) @(negedge clk);
    req_valid[k] = 1'b1;
    req_we[k]    = we;
    req_addr[k]  = a;
    req_wdata[k] = d;
    exp_addr[k]  = a;
    exp_wd[k]    = d;
    if (!we) exp_rd[k] = ref_mem[k][a[9:0]];
    rc0 = rd_cnt[k];
    @(negedge clk);
    while (!req_ready[k]) begin
      busy++;
      req_we[k]    = ~we;
      req_addr[k]  = 19'($urandom);
      req_wdata[k] = 8'($urandom);
      @(negedge clk);
    end
    req_valid[k] = 1'b0;
    if (!we) expd = RD + TURN;
    else if (k == 0) expd = TURN + WPH + HOLD + TURN;
    else expd = WPL + HOLD + TURN;
    chk(busy == expd, "R8 busy length", busy, expd);
    chk(rd_cnt[k] - rc0 == (we ? 0 : 1), "R3 read pulses per access", rd_cnt[k] - rc0, we ? 0 : 1);
    if (we) ref_mem[k][a[9:0]] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin
      req_valid[k] = 1'b0; req_we[k] = 1'b0; req_addr[k] = '0; req_wdata[k] = '0;
      exp_addr[k] = '0; exp_wd[k] = '0; exp_rd[k] = '0; rd_cnt[k] = 0;
      for (int i = 0; i < 1024; i++) ref_mem[k][i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        // R1: idle state out of reset, no request
        chk(cs_n[k] && we_n[k] && oe_n[k], "R1 strobes idle", int'({cs_n[k], we_n[k], oe_n[k]}), 7);
        chk(!dq_oe[k] && !rd_valid[k] && req_ready[k], "R1 bus off and ready",
            int'({dq_oe[k], rd_valid[k], req_ready[k]}), 1);
      end
    end
    for (int k = 0; k < 2; k++) begin
      op(k, 1'b1, 19'h7FFFF, 8'hA5);
      op(k, 1'b1, 19'h00000, 8'h5A);
      op(k, 1'b0, 19'h7FFFF, 8'h00);
      op(k, 1'b0, 19'h00000, 8'h00);
      op(k, 1'b1, 19'h12345, 8'h01);
      op(k, 1'b1, 19'h12345, 8'hFE);
      op(k, 1'b0, 19'h12345, 8'h00);
      op(k, 1'b0, 19'h00010, 8'h00);
      for (int n = 0; n < 200; n++) begin
        logic [18:0] a;
        a = 19'($urandom);
        if ($urandom % 4 != 0) a[9:4] = 6'd0;
        op(k, 1'($urandom), a, 8'($urandom));
      end
    end
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule